// File: doc/BRIEF.md
# Pattern Rotating Serial Signal Generator

This block turns a 64-bit pattern into two bit-serial waveforms. Software writes two 32-bit shadow words, a step-rate divide value, a run length and an enable bit. The block then rotates the combined pattern right by one position on each step tick. Two fixed taps on the pattern drive a serial data line and a serial clock line. With bits 15:0 holding the data stream and bits 31:16 holding the clock stream, the block can act as an SPI-style transmitter in any clock polarity and phase setting. Each data bit is written twice in a row, and the clock toggles between the two copies.

A run is one-shot. After the programmed number of steps the active pattern reloads from the shadow words, the enable bit clears itself and a sticky done flag is set. The done flag can raise an interrupt. Software refills the words and sets enable again to start the next run.

Top module: `sg_rot_gen`

## Requirements
- R1: After reset, every readable register reads 0, and `ser_data_o`, `ser_clk_o` and `irq_o` are low. The register addresses are: control at 0, divide at 1, word 0 at 2, word 1 at 3 and status at 4.
- R2: While no run is active, `ser_data_o` equals bit 0 of word 0 (address 2) and `ser_clk_o` equals bit 16 of word 0. Both follow a write to word 0 one clock after the write edge.
- R3: Let P = {word1, word0}, with word 1 in bits 63:32. After k steps of a run, `ser_data_o` = P[k mod 64] and `ser_clk_o` = P[(k+16) mod 64]. This is a right rotation in which bit 0 wraps into bit 63.
- R4: With N in divide bits 15:0, the first step occurs N+1 clocks after the clock edge that takes the enable write. Each later step follows N+1 clocks after the one before it.
- R5: A write of 1 to control bit 0 while idle starts a run of L steps, where L is control bits 13:8 and L = 0 means 64. On the L-th step the pattern reloads from the words, and control bit 0 then reads 0.
- R6: Status bit 0 (done) is set when a run completes. It stays set until software writes 1 to status bit 0. If a completion and a clear write fall on the same edge, done ends up set.
- R7: `irq_o` is high exactly when done is set and control bit 1 (interrupt enable) is 1.
- R8: Writes to the words during a run do not change the active pattern or the serial outputs. The new values appear at the reload that ends the run.
- R9: A write of 0 to control bit 0 during a run stops the run without setting done. The outputs return to the idle values taken from word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ser_data_o | output | 1 | Serial data tap (pattern bit 0) |
| ser_clk_o | output | 1 | Serial clock tap (pattern bit 16) |
| irq_o | output | 1 | Done interrupt, masked by the interrupt enable |

## Verification
The assertions assume the following about the inputs:
- Register writes arrive as single-cycle strobes with address and data stable at the edge.
- The divide value is not changed in the middle of a run. The tick-spacing property relies on this.

The stimulus sets the divide value and the length only while the block is idle. It changes only the shadow words or the enable bit during a run, and it places every write a whole number of clocks after the start edge. This lets the expected output for each cycle be computed from the write edge alone.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SG_ADDR_W    = 3;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_DIV     = 1;
  localparam int ADDR_WORD0   = 2;
  localparam int ADDR_STAT    = 4;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int CTRL_LEN_LSB = 8;
  localparam int STAT_DONE    = 0;
endpackage

// File: rtl/sg_regs.sv
module sg_regs
  import sg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SG_ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic                     run_i,
  input  logic                     finish_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic [NWORDS*WORD_W-1:0] words_o,
  output logic [DIV_W-1:0]         div_o,
  output logic [LEN_W-1:0]         len_o,
  output logic                     irq_en_o,
  output logic                     done_o,
  output logic                     en_set_o,
  output logic                     en_clr_o
);
  logic             wr_ctrl, wr_div, wr_stat;
  logic [WORD_W-1:0] word_q [NWORDS];
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;
  logic             ie_q, done_q;

  assign wr_ctrl = wr_en_i && (addr_i == SG_ADDR_W'(ADDR_CTRL));
  assign wr_div  = wr_en_i && (addr_i == SG_ADDR_W'(ADDR_DIV));
  assign wr_stat = wr_en_i && (addr_i == SG_ADDR_W'(ADDR_STAT));

  assign en_set_o = wr_ctrl &&  wdata_i[CTRL_EN_BIT];
  assign en_clr_o = wr_ctrl && !wdata_i[CTRL_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      ie_q  <= 1'b0;
    end else if (wr_ctrl) begin
      len_q <= wdata_i[CTRL_LEN_LSB +: LEN_W];
      ie_q  <= wdata_i[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (wr_div) div_q <= wdata_i[DIV_W-1:0];
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            done_q <= 1'b0;
    else if (finish_i)                      done_q <= 1'b1;
    else if (wr_stat && wdata_i[STAT_DONE]) done_q <= 1'b0;
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[i] <= '0;
      else if (wr_en_i && (addr_i == SG_ADDR_W'(ADDR_WORD0 + i))) word_q[i] <= wdata_i;
    end
    assign words_o[i*WORD_W +: WORD_W] = word_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == SG_ADDR_W'(ADDR_CTRL)) begin
      rdata_o[CTRL_EN_BIT]                = run_i;
      rdata_o[CTRL_IE_BIT]                = ie_q;
      rdata_o[CTRL_LEN_LSB +: LEN_W]      = len_q;
    end
    if (addr_i == SG_ADDR_W'(ADDR_DIV))  rdata_o[DIV_W-1:0] = div_q;
    if (addr_i == SG_ADDR_W'(ADDR_STAT)) rdata_o[STAT_DONE] = done_q;
    for (int i = 0; i < NWORDS; i++) begin
      if (addr_i == SG_ADDR_W'(ADDR_WORD0 + i)) rdata_o = word_q[i];
    end
  end

  assign div_o    = div_q;
  assign len_o    = len_q;
  assign irq_en_o = ie_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sg_step_div.sv
module sg_step_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sg_run_ctrl.sv
module sg_run_ctrl #(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             run_o,
  output logic             start_o,
  output logic             finish_o
);
  localparam logic [LEN_W:0] FULL_LEN = {1'b1, {LEN_W{1'b0}}};

  logic             run_q;
  logic [LEN_W:0]   steps_q, steps_nx, len_eff;

  assign len_eff  = (len_i == '0) ? FULL_LEN : {1'b0, len_i};
  assign steps_nx = steps_q + 1'b1;
  assign start_o  = en_set_i && !run_q;
  assign finish_o = run_q && tick_i && (steps_nx >= len_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      steps_q <= '0;
    end else if (start_o) begin
      run_q   <= 1'b1;
      steps_q <= '0;
    end else if (finish_o || (run_q && en_clr_i)) begin
      run_q   <= 1'b0;
      steps_q <= '0;
    end else if (run_q && tick_i) begin
      steps_q <= steps_nx;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/sg_pattern.sv
module sg_pattern #(
  parameter int PAT_W    = 64,
  parameter int DATA_TAP = 0,
  parameter int CLK_TAP  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [PAT_W-1:0] shadow_i,
  output logic [PAT_W-1:0] pat_o,
  output logic             data_o,
  output logic             clk_o
);
  logic [PAT_W-1:0] pat_q, rot;

  for (genvar b = 0; b < PAT_W; b++) begin : g_rot
    assign rot[b] = pat_q[(b + 1) % PAT_W];
  end

  // idle: pattern follows the shadow words every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pat_q <= '0;
    else if (load_i) pat_q <= shadow_i;
    else if (step_i) pat_q <= rot;
  end

  assign pat_o  = pat_q;
  assign data_o = pat_q[DATA_TAP];
  assign clk_o  = pat_q[CLK_TAP];
endmodule

// File: rtl/sg_rot_gen.sv
module sg_rot_gen
  import sg_pkg::*;
#(
  parameter int PAT_W    = 64,
  parameter int WORD_W   = 32,
  parameter int DIV_W    = 16,
  parameter int LEN_W    = 6,
  parameter int DATA_TAP = 0,
  parameter int CLK_TAP  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SG_ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 ser_data_o,
  output logic                 ser_clk_o,
  output logic                 irq_o
);
  localparam int NWORDS = PAT_W / WORD_W;

  logic [PAT_W-1:0] words, pat_q;
  logic [DIV_W-1:0] div;
  logic [LEN_W-1:0] len;
  logic irq_en, done, en_set, en_clr, run, start, finish, tick;

  sg_regs #(.WORD_W(WORD_W), .NWORDS(NWORDS), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .run_i(run), .finish_i(finish), .rdata_o,
    .words_o(words), .div_o(div), .len_o(len), .irq_en_o(irq_en),
    .done_o(done), .en_set_o(en_set), .en_clr_o(en_clr)
  );

  sg_run_ctrl #(.LEN_W(LEN_W)) u_run (
    .clk_i, .rst_ni, .en_set_i(en_set), .en_clr_i(en_clr), .tick_i(tick),
    .len_i(len), .run_o(run), .start_o(start), .finish_o(finish)
  );

  sg_step_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .restart_i(start), .run_i(run), .div_i(div), .tick_o(tick)
  );

  sg_pattern #(.PAT_W(PAT_W), .DATA_TAP(DATA_TAP), .CLK_TAP(CLK_TAP)) u_pat (
    .clk_i, .rst_ni, .load_i(!run || finish), .step_i(tick), .shadow_i(words),
    .pat_o(pat_q), .data_o(ser_data_o), .clk_o(ser_clk_o)
  );

  assign irq_o = done && irq_en;
endmodule

// File: rtl/sg_rot_gen_chk.sv
module sg_rot_gen_chk #(
  parameter int PAT_W = 64,
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             tick,
  input logic             finish,
  input logic             en_clr,
  input logic             done,
  input logic             irq_en,
  input logic             irq_o,
  input logic             stat_clr,
  input logic [DIV_W-1:0] div,
  input logic [PAT_W-1:0] pat
);
  // R3
  a_r3_rotate_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && tick && !finish && !en_clr |=> pat == {$past(pat[0]), $past(pat[PAT_W-1:1])});
  // R4
  a_r4_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && div != '0 |=> !tick || div == '0);
  // R5
  a_r5_self_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> !run);
  // R6
  a_r6_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> done);
  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !stat_clr |=> done);
  // R7
  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq_o);
  // R8
  a_r8_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !tick |=> $stable(pat));
endmodule

bind sg_rot_gen sg_rot_gen_chk #(.PAT_W(PAT_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .tick(tick), .finish(finish),
  .en_clr(en_clr), .done(done), .irq_en(irq_en), .irq_o(irq_o),
  .stat_clr(wr_en_i && (addr_i == 3'd4) && wdata_i[0]),
  .div(div), .pat(pat_q)
);

// File: tb/tb_sg_rot_gen.sv
`timescale 1ns/1ps
module tb_sg_rot_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ser_data, ser_clk, irq;

  always #2 clk = ~clk;

  sg_rot_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ser_data_o(ser_data), .ser_clk_o(ser_clk), .irq_o(irq)
  );

  typedef struct { logic d; logic c; string req; } exp_t;
  exp_t q[$];
  exp_t e;
  bit   armed = 1'b0;
  bit   ended = 1'b0;
  int   n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: one expected item per clock while armed
  initial forever begin
    @(posedge clk); #1;
    if (armed) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.req, " data"}, {31'd0, ser_data}, {31'd0, e.d});
        chk({e.req, " clk"},  {31'd0, ser_clk},  {31'd0, e.c});
      end
      if (q.size() == 0) armed = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic start(input logic [31:0] ctrl);
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = ctrl;
    @(posedge clk); armed = 1'b1; #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  // expected taps per clock from the start edge through the reload
  task automatic push_run(input logic [63:0] p, input logic [63:0] pnew,
                          input int n, input int l, input string req);
    int len = (l == 0) ? 64 : l;
    int total = len * (n + 1);
    for (int m = 0; m <= total + 1; m++) begin
      exp_t x;
      if (m < total) begin
        int k = m / (n + 1);
        x.d = p[k % 64]; x.c = p[(k + 16) % 64];
      end else begin
        x.d = pnew[0]; x.c = pnew[16];
      end
      x.req = req;
      q.push_back(x);
    end
  endtask

  logic [31:0] v;
  logic [63:0] p, pn;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 32'd0);
    end
    chk("R1 outs", {29'd0, ser_data, ser_clk, irq}, 32'd0);

    // R2 idle taps follow word 0
    wr(3'd2, 32'h0000_0001); @(posedge clk); #1;
    chk("R2 data", {31'd0, ser_data}, 32'd1);
    chk("R2 clk",  {31'd0, ser_clk},  32'd0);
    wr(3'd2, 32'h0001_0000); @(posedge clk); #1;
    chk("R2 data", {31'd0, ser_data}, 32'd0);
    chk("R2 clk",  {31'd0, ser_clk},  32'd1);

    // R3/R5: SPI-style run, divide 0, 16 steps
    wr(3'd2, 32'hAAAA_F0CF); wr(3'd3, 32'h1234_5678); wr(3'd1, 32'd0);
    p = {32'h1234_5678, 32'hAAAA_F0CF};
    push_run(p, p, 0, 16, "R3/R5");
    start((32'd16 << 8) | 32'd1);
    wait (armed == 1'b0);
    rd(3'd0, v); chk("R5 enable self-clear", v & 32'd1, 32'd0);
    rd(3'd4, v); chk("R6 done set", v, 32'd1);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R6 done cleared", v, 32'd0);

    // R4: divide 2, length 0 = 64 steps with full wrap
    wr(3'd2, 32'hC3A5_961E); wr(3'd3, 32'h7E81_4BD2); wr(3'd1, 32'd2);
    p = {32'h7E81_4BD2, 32'hC3A5_961E};
    push_run(p, p, 2, 0, "R4/R3");
    start(32'd1);
    wait (armed == 1'b0);
    rd(3'd4, v); chk("R5 done after 64", v, 32'd1);
    wr(3'd4, 32'd1);

    // R8: word writes mid-run, R7 irq enabled
    wr(3'd2, 32'h5555_00FF); wr(3'd3, 32'd0); wr(3'd1, 32'd1);
    p  = {32'd0, 32'h5555_00FF};
    pn = {32'd0, 32'h00FF_FF00};
    push_run(p, pn, 1, 5, "R8");
    start((32'd5 << 8) | 32'd3);
    wr(3'd2, 32'h00FF_FF00);
    wait (armed == 1'b0);
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'd1);
    chk("R7 irq low", {31'd0, irq}, 32'd0);
    rd(3'd4, v); chk("R6 w1c", v, 32'd0);

    // R6: clear lands on the completion edge, set wins
    wr(3'd1, 32'd0);
    start((32'd3 << 8) | 32'd1);
    repeat (2) @(posedge clk);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R6 set wins", v, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R6 cleared", v, 32'd0);

    // R9: abort mid-run
    wr(3'd2, 32'h0000_0001); wr(3'd1, 32'd3);
    start((32'd20 << 8) | 32'd1);
    repeat (6) @(posedge clk); #1;
    chk("R9 rotated", {31'd0, ser_data}, 32'd0);
    wr(3'd0, 32'd20 << 8);
    rd(3'd0, v); chk("R9 stopped", v & 32'd1, 32'd0);
    repeat (2) @(posedge clk); #1;
    chk("R9 idle data", {31'd0, ser_data}, 32'd1);
    chk("R9 idle clk",  {31'd0, ser_clk},  32'd0);
    rd(3'd4, v); chk("R9 no done", v, 32'd0);

    summary();
  end
endmodule